// File: doc/BRIEF.md
# Dual-Mode FIFO with Status Flags

This block is a dual-clock FIFO. A write port and a read port each run on their own clock. Its four status outputs are active low, and two of them change meaning with a static mode input. In standard mode, a read request moves the oldest word from storage into the output register on the next read-clock edge. In first-word-fall-through mode, the oldest word is moved into the output register without being asked for. A read request then consumes it. Because of this output register, the FIFO holds one word more than its storage depth in this mode.

The write and read pointers cross between the two clock domains as Gray code, through two-flop synchronisers. Write-side flags are updated on the write clock and read-side flags on the read clock. When a word crosses the boundary, the flags on the far side settle a few cycles later. The almost-full and almost-empty thresholds come from two offset inputs. Both offsets and the mode are held steady while the FIFO is in use, and are changed only under reset.

Top module: `dual_mode_fifo_flags`

## Requirements
- R1: While both resets are high, `full_ir` reads 1 in standard mode and 0 in fall-through mode. `empty_or` reads 0 in standard mode and 1 in fall-through mode. `afull_n` and `aempty_n` both read 1.
- R2: In standard mode, `full_ir` drops to 0 once D words are stored, where D = 2**DEPTH_LOG2. A write request while it is 0 is discarded, and that word never appears at the read port.
- R3: In fall-through mode, `full_ir` rises to 1 once D+1 words are held. A write request while it is 1 is discarded.
- R4: In standard mode, `empty_or` is 0 exactly when no word is stored. A read request while it is 0 leaves `rd_data` unchanged.
- R5: In fall-through mode, `empty_or` falls to 0 in the same read-clock cycle in which the oldest word appears on `rd_data`. No read request is needed for this.
- R6: In fall-through mode, `empty_or` rises to 1 only after a read-clock edge with `rd_req` high. After the last word has been read, `rd_data` keeps that word, and further read requests are ignored.
- R7: `afull_n` is 0 when the number of words held is at least D−m in standard mode, or at least D+1−m in fall-through mode, where m = `afull_ofs`. Otherwise it is 1.
- R8: `aempty_n` is 0 when the number of words held is at most n in standard mode, or at most n+1 in fall-through mode, where n = `aempty_ofs`. Otherwise it is 1.
- R9: Words leave the FIFO in the order in which they were accepted. In standard mode, a read accepted at one read-clock edge presents its word on `rd_data` after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_req | input | 1 | Write request, active high |
| wr_data | input | DATA_W | Word to write |
| afull_ofs | input | DEPTH_LOG2 | Almost-full offset m |
| full_ir | output | 1 | Full flag (standard, active low) / input-ready (fall-through, high = no room) |
| afull_n | output | 1 | Almost-full flag, active low |
| rd_clk | input | 1 | Read clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_req | input | 1 | Read request, active high |
| aempty_ofs | input | DEPTH_LOG2 | Almost-empty offset n |
| rd_data | output | DATA_W | Output register |
| empty_or | output | 1 | Empty flag (standard, active low) / output-ready (fall-through, high = nothing valid) |
| aempty_n | output | 1 | Almost-empty flag, active low |
| fwft_mode | input | 1 | 0 = standard, 1 = first-word-fall-through |

## Verification
An accepted write reaches the read side after about three read-clock edges: the Gray register, two synchroniser stages, then one more edge for the fall-through fetch and the registered almost-empty flag. A pointer change on the read side takes a similar path back to the write-side flags. For this reason the bench drives each request for one cycle and then waits sixteen write-clock cycles, which covers both round trips with margin. Only then does it compare all four flags and `rd_data` with a word count kept arithmetically in the bench. The bench sweeps every fill level from empty to beyond capacity and back, in both modes and for three offset pairs.

// File: rtl/ffl_pkg.sv
package ffl_pkg;

    localparam int GRAY_W = 16;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    function automatic logic [GRAY_W-1:0] to_gray(input logic [GRAY_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GRAY_W-1:0] from_gray(input logic [GRAY_W-1:0] g);
        logic [GRAY_W-1:0] b;
        b[GRAY_W-1] = g[GRAY_W-1];
        for (int i = GRAY_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/ffl_sync.sv
module ffl_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ffl_wr_ctrl.sv
module ffl_wr_ctrl
    import ffl_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  fifo_mode_e    mode,
    input  logic          wr_req,
    input  logic [AW-1:0] afull_ofs,
    input  logic [AW:0]   rd_gray_sync,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW:0]   wr_gray,
    output logic          full_ir,
    output logic          afull_n
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH = PW'(1 << AW);

    logic [PW-1:0] wptr, wptr_nxt, rptr_bin, used, thresh;
    logic          full;

    assign rptr_bin = PW'(from_gray(GRAY_W'(rd_gray_sync)));
    assign used     = wptr - rptr_bin;
    assign full     = (used == DEPTH);
    assign wr_en    = wr_req && !full;
    assign wptr_nxt = wptr + PW'(wr_en);
    assign wr_addr  = wptr[AW-1:0];
    assign thresh   = DEPTH - {1'b0, afull_ofs};

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            wr_gray <= '0;
        end else begin
            wptr    <= wptr_nxt;
            wr_gray <= PW'(to_gray(GRAY_W'(wptr_nxt)));
        end
    end

    assign full_ir = (mode == MODE_FWFT) ? full : !full;
    assign afull_n = !(used >= thresh);

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        used <= DEPTH);
    p_write_blocked_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_req && full) |=> $stable(wptr));
    p_afull_with_full_r7: assert property (@(posedge clk) disable iff (rst)
        full |-> !afull_n);
endmodule

// File: rtl/ffl_rd_ctrl.sv
module ffl_rd_ctrl
    import ffl_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  fifo_mode_e    mode,
    input  logic          rd_req,
    input  logic [AW-1:0] aempty_ofs,
    input  logic [AW:0]   wr_gray_sync,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          empty_or,
    output logic          aempty_n
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH = PW'(1 << AW);

    logic [PW-1:0] rptr, wptr_bin, avail;
    logic          valid, has, pop, low_std, low_fwft;

    assign wptr_bin = PW'(from_gray(GRAY_W'(wr_gray_sync)));
    assign avail    = wptr_bin - rptr;
    assign has      = (avail != '0);
    assign pop      = (mode == MODE_FWFT) ? (has && (!valid || rd_req))
                                          : (has && rd_req);
    assign rd_addr  = rptr[AW-1:0];

    assign low_std  = (avail <= {1'b0, aempty_ofs});
    assign low_fwft = (({1'b0, avail} + (PW+1)'(valid)) <= ({2'b0, aempty_ofs} + (PW+1)'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr     <= '0;
            valid    <= 1'b0;
            rd_data  <= '0;
            aempty_n <= 1'b1;
        end else begin
            if (pop) begin
                rptr    <= rptr + PW'(1);
                rd_data <= mem_rdata;
            end
            if (mode == MODE_FWFT) begin
                if (pop)         valid <= 1'b1;
                else if (rd_req) valid <= 1'b0;
            end else begin
                valid <= 1'b0;
            end
            aempty_n <= (mode == MODE_FWFT) ? !low_fwft : !low_std;
        end
    end

    assign empty_or = (mode == MODE_FWFT) ? !valid : has;

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        avail <= DEPTH);
    p_std_empty_read_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STD && !has) |=> $stable(rd_data));
    p_or_rises_on_read_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FWFT && $rose(empty_or)) |-> $past(rd_req));
    p_last_word_held_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FWFT && empty_or && !has) |=> $stable(rd_data));
endmodule

// File: rtl/dual_mode_fifo_flags.sv
module dual_mode_fifo_flags
    import ffl_pkg::*;
#(
    parameter int DATA_W     = 9,
    parameter int DEPTH_LOG2 = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  wr_clk,
    input  logic                  wr_rst,
    input  logic                  wr_req,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [DEPTH_LOG2-1:0] afull_ofs,
    output logic                  full_ir,
    output logic                  afull_n,
    input  logic                  rd_clk,
    input  logic                  rd_rst,
    input  logic                  rd_req,
    input  logic [DEPTH_LOG2-1:0] aempty_ofs,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  empty_or,
    output logic                  aempty_n,
    input  logic                  fwft_mode
);
    localparam int AW    = DEPTH_LOG2;
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    fifo_mode_e        mode;
    logic              wr_en;
    logic [AW-1:0]     wr_addr, rd_addr;
    logic [PW-1:0]     wr_gray, rd_gray, wr_gray_rs, rd_gray_ws;
    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] mem_rdata;

    assign mode = fifo_mode_e'(fwft_mode);

    always_ff @(posedge wr_clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end
    assign mem_rdata = store[rd_addr];

    ffl_wr_ctrl #(.AW(AW)) wr_ctrl_i (
        .clk(wr_clk), .rst(wr_rst), .mode(mode), .wr_req(wr_req),
        .afull_ofs(afull_ofs), .rd_gray_sync(rd_gray_ws), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_gray(wr_gray), .full_ir(full_ir), .afull_n(afull_n)
    );

    ffl_rd_ctrl #(.AW(AW), .DW(DATA_W)) rd_ctrl_i (
        .clk(rd_clk), .rst(rd_rst), .mode(mode), .rd_req(rd_req),
        .aempty_ofs(aempty_ofs), .wr_gray_sync(wr_gray_rs), .mem_rdata(mem_rdata),
        .rd_addr(rd_addr), .rd_data(rd_data), .empty_or(empty_or), .aempty_n(aempty_n)
    );

    ffl_sync #(.W(PW), .STAGES(SYNC_STAGES)) w2r_i (
        .clk(rd_clk), .rst(rd_rst), .d(wr_gray), .q(wr_gray_rs)
    );
    ffl_sync #(.W(PW), .STAGES(SYNC_STAGES)) r2w_i (
        .clk(wr_clk), .rst(wr_rst), .d(rd_gray), .q(rd_gray_ws)
    );

    assign rd_gray = PW'(to_gray(GRAY_W'(rd_ctrl_i.rptr)));
endmodule

// File: tb/dual_mode_fifo_flags_tb.sv
module dual_mode_fifo_flags_tb_top;
    localparam int DW = 9;
    localparam int AW = 4;
    localparam int D  = 1 << AW;

    logic wr_clk = 0, rd_clk = 0;
    logic wr_rst = 1, rd_rst = 1, wr_req = 0, rd_req = 0, fwft_mode = 0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] afull_ofs = '0, aempty_ofs = '0;
    logic full_ir, afull_n, empty_or, aempty_n;
    logic [DW-1:0] rd_data;

    int vectors = 0, errors = 0;

    always #2.5 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    dual_mode_fifo_flags #(.DATA_W(DW), .DEPTH_LOG2(AW)) dut_i (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_req(wr_req), .wr_data(wr_data),
        .afull_ofs(afull_ofs), .full_ir(full_ir), .afull_n(afull_n),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_req(rd_req), .aempty_ofs(aempty_ofs),
        .rd_data(rd_data), .empty_or(empty_or), .aempty_n(aempty_n), .fwft_mode(fwft_mode)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic settle();
        repeat (16) @(negedge wr_clk);
    endtask

    function automatic logic [DW-1:0] word_of(input int mode, input int cfg, input int k);
        return DW'((mode * 64 + cfg * 21 + k * 7 + 1) % 512);
    endfunction

    task automatic check_flags(input int mode, input int total, input int m, input int n);
        logic e_full, e_af, e_emp, e_ae;
        if (mode == 0) begin
            e_full = !(total == D);       // R2
            e_af   = !(total >= D - m);   // R7
            e_emp  = (total != 0);        // R4
            e_ae   = !(total <= n);       // R8
        end else begin
            e_full = (total == D + 1);    // R3
            e_af   = !(total >= D + 1 - m);
            e_emp  = (total == 0);        // R6
            e_ae   = !(total <= n + 1);
        end
        check(full_ir == e_full, mode ? "R3 input-ready" : "R2 full", full_ir, e_full);
        check(afull_n == e_af, "R7 almost-full", afull_n, e_af);
        check(empty_or == e_emp, mode ? "R6 output-ready" : "R4 empty", empty_or, e_emp);
        check(aempty_n == e_ae, "R8 almost-empty", aempty_n, e_ae);
    endtask

    initial begin
        #600us;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int mode = 0; mode < 2; mode++) begin
            for (int cfg = 0; cfg < 3; cfg++) begin
                int m, n, total, ri, cap;
                logic [DW-1:0] prev, exp;
                m = cfg * 3;
                n = cfg * 2 + 1;
                cap = (mode == 1) ? D + 1 : D;
                // reset with new configuration
                @(negedge wr_clk);
                wr_rst = 1; rd_rst = 1;
                fwft_mode = logic'(mode);
                afull_ofs = AW'(m); aempty_ofs = AW'(n);
                repeat (6) @(negedge rd_clk);
                // R1 reset values
                check(full_ir == (mode == 0), "R1 full_ir", full_ir, mode == 0);
                check(empty_or == (mode == 1), "R1 empty_or", empty_or, mode == 1);
                check(afull_n == 1'b1, "R1 afull_n", afull_n, 1);
                check(aempty_n == 1'b1, "R1 aempty_n", aempty_n, 1);
                @(negedge wr_clk); wr_rst = 0;
                @(negedge rd_clk); rd_rst = 0;
                settle();
                total = 0;
                check_flags(mode, total, m, n);
                // fill beyond capacity, one word at a time
                for (int k = 0; k < D + 3; k++) begin
                    @(negedge wr_clk);
                    wr_req = 1; wr_data = word_of(mode, cfg, k);
                    @(negedge wr_clk);
                    wr_req = 0;
                    if (total < cap) total++;
                    settle();
                    check_flags(mode, total, m, n);
                    if (mode == 1 && k == 0) begin
                        // R5: word shown while output-ready is low
                        check(rd_data == word_of(mode, cfg, 0), "R5 first word", rd_data, word_of(mode, cfg, 0));
                        check(empty_or == 1'b0, "R5 output-ready", empty_or, 0);
                    end
                end
                // drain beyond empty, one read at a time
                ri = 0;
                for (int k = 0; k < D + 3; k++) begin
                    prev = rd_data;
                    @(negedge rd_clk);
                    rd_req = 1;
                    @(negedge rd_clk);
                    rd_req = 0;
                    if (total > 0) begin
                        if (mode == 0) begin
                            exp = word_of(mode, cfg, ri);
                            ri++; total--;
                        end else begin
                            ri++; total--;
                            exp = (total > 0) ? word_of(mode, cfg, ri) : prev;
                        end
                    end else begin
                        exp = prev;
                    end
                    settle();
                    if (total == 0 && exp == prev)
                        check(rd_data == exp, mode ? "R6 last word held" : "R4 read ignored", rd_data, exp);
                    else
                        check(rd_data == exp, "R9 order", rd_data, exp);
                    check_flags(mode, total, m, n);
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule